// File: doc/BRIEF.md
# Serial CRC Division Register

This block divides a serial bit stream by a fixed generator polynomial over GF(2) and leaves the remainder in a shift register. A message begins with a one-cycle start strobe, which clears the register. Information bits then arrive one per clock while a valid qualifier is high, the highest-order coefficient first, and a last-bit marker closes the message. After that bit the block feeds R zero bits through the same divider by itself, one per clock. It then raises a one-cycle done pulse and holds the remainder until the next start.

On the sending side the held remainder is the set of R check bits that follow the information bits on the line. The result is a codeword that is an exact multiple of the generator. On the receiving side the whole received codeword goes through the same path. A remainder of zero means no error was seen, and any other value raises the error output. The generator is chosen by a degree parameter and a coefficient mask, so the usual 8-, 16- and 32-bit generators need no change to the logic.

Top module: `serial_crc_div`

## Requirements
- R1: A start strobe clears the remainder to all zeros, drops done and resultValid, and makes busy high in the next cycle. Start may come at any time, including in the middle of a message, and it overrides everything else.
- R2: While a message is being fed, a bit is taken only in a cycle where bitValid is high. The first bit taken is the highest-order coefficient. bitValid and bitLast are ignored while the block is idle, and bitLast is ignored in a cycle where bitValid is low.
- R3: The bit taken with bitLast high is followed by exactly POLY_DEG division steps with a zero input. bitValid, bitIn and bitLast have no effect during these steps.
- R4: done is high for exactly one cycle. That cycle follows the last zero step, which puts it POLY_DEG cycles after the cycle in which the last bit was taken. In that cycle, remainder equals x^POLY_DEG * m(x) mod g(x), where m(x) is the sequence of bits taken.
- R5: From the done cycle until the next start, resultValid is high and remainder does not change.
- R6: With POLY_DEG=3 and POLY_TAPS=3'b011 (g = x^3+x+1), the input 1100 gives the remainder 010.
- R7: chkErr is high exactly when resultValid is high and remainder is nonzero. A codeword made of information bits followed by their remainder gives chkErr low. A codeword with one bit flipped gives chkErr high.
- R8: POLY_TAPS bit j is the coefficient of x^j in g(x), and x^POLY_DEG is implied. With POLY_DEG=16, POLY_TAPS=16'h1021 and with POLY_DEG=32, POLY_TAPS=32'h04C11DB7, the block meets R4 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clear the register and begin a message |
| bitValid | input | 1 | bitIn carries a message bit this cycle |
| bitIn | input | 1 | Serial message bit, highest order first |
| bitLast | input | 1 | With bitValid: this is the final message bit |
| remainder | output | POLY_DEG | Division register contents; bit j is the coefficient of x^j |
| busy | output | 1 | A message is being taken or flushed |
| done | output | 1 | One-cycle pulse when the remainder is final |
| resultValid | output | 1 | Remainder is final and held |
| chkErr | output | 1 | Final remainder is nonzero |

## Verification
The bench goes after the bit-ordering corner: the 1100 case shows whether the highest coefficient is taken first, since a design that reverses the order gives a different remainder. It runs several generator widths at once with valid gaps and noise on the inputs during flush and idle. A design that counts flush steps wrongly puts done in the wrong cycle, and one that listens to bitValid during flush or idle corrupts or moves the remainder. Codewords built by the bench model, with and without a single flipped bit, show whether the zero-remainder check and the error flag work. A start in the middle of a message shows whether the restart clears stale state.

// File: rtl/crc_div_pkg.sv
package crc_div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FEED  = 2'd1,
    ST_FLUSH = 2'd2
  } div_state_t;

  typedef struct packed {
    logic clear;    // zero the register this edge
    logic shift;    // perform one division step this edge
    logic useZero;  // step input is forced to zero (flush)
  } div_strobe_t;

endpackage

// File: rtl/crc_div_ctrl.sv
module crc_div_ctrl
  import crc_div_pkg::*;
#(
  parameter int POLY_DEG = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        bitValid,
  input  logic        bitLast,
  output div_strobe_t strobe,
  output logic        busy,
  output logic        done,
  output logic        resultValid
);

  localparam int CNT_W = $clog2(POLY_DEG + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(POLY_DEG - 1);

  div_state_t       stateQ;
  logic [CNT_W-1:0] flushCnt;
  logic             lastFlush;

  assign lastFlush = (stateQ == ST_FLUSH) && (flushCnt == LAST_STEP) && !start;
  assign busy      = (stateQ != ST_IDLE);

  always_comb begin
    strobe = '0;
    if (start) begin
      strobe.clear = 1'b1;
    end else begin
      case (stateQ)
        ST_FEED:  strobe.shift = bitValid;
        ST_FLUSH: begin
          strobe.shift   = 1'b1;
          strobe.useZero = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ      <= ST_IDLE;
      flushCnt    <= '0;
      done        <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      done <= lastFlush;
      if (start) begin
        stateQ      <= ST_FEED;
        flushCnt    <= '0;
        resultValid <= 1'b0;
      end else begin
        case (stateQ)
          ST_FEED: begin
            if (bitValid && bitLast) begin
              stateQ   <= ST_FLUSH;
              flushCnt <= '0;
            end
          end
          ST_FLUSH: begin
            if (lastFlush) begin
              stateQ      <= ST_IDLE;
              resultValid <= 1'b1;
            end else begin
              flushCnt <= flushCnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_DONE_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(stateQ) == ST_FLUSH)); // R3
  AST_FLUSH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_FLUSH) |-> (flushCnt < CNT_W'(POLY_DEG))); // R3
  AST_DONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> resultValid); // R5

endmodule

// File: rtl/crc_div_dp.sv
module crc_div_dp
  import crc_div_pkg::*;
#(
  parameter int                  POLY_DEG  = 16,
  parameter logic [POLY_DEG-1:0] POLY_TAPS = 16'h1021
) (
  input  logic                clk,
  input  logic                rst_n,
  input  div_strobe_t         strobe,
  input  logic                bitIn,
  output logic [POLY_DEG-1:0] remQ
);

  logic [POLY_DEG-1:0] remNxt;
  logic                topBit;
  logic                stepIn;

  assign topBit = remQ[POLY_DEG-1];
  assign stepIn = strobe.useZero ? 1'b0 : bitIn;

  // One long-division step: shift the new bit in at the bottom and
  // subtract g(x) whenever a 1 leaves the top stage.
  for (genvar j = 0; j < POLY_DEG; j++) begin : g_stage
    if (j == 0) begin : g_bottom
      assign remNxt[j] = stepIn ^ (POLY_TAPS[j] & topBit);
    end else begin : g_upper
      assign remNxt[j] = remQ[j-1] ^ (POLY_TAPS[j] & topBit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remQ <= '0;
    end else if (strobe.clear) begin
      remQ <= '0;
    end else if (strobe.shift) begin
      remQ <= remNxt;
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clear |=> (remQ == '0)); // R1
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.clear && !strobe.shift) |=> $stable(remQ)); // R2

endmodule

// File: rtl/serial_crc_div.sv
module serial_crc_div
  import crc_div_pkg::*;
#(
  parameter int                  POLY_DEG  = 16,
  parameter logic [POLY_DEG-1:0] POLY_TAPS = 16'h1021
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                bitValid,
  input  logic                bitIn,
  input  logic                bitLast,
  output logic [POLY_DEG-1:0] remainder,
  output logic                busy,
  output logic                done,
  output logic                resultValid,
  output logic                chkErr
);

  div_strobe_t strobe;

  crc_div_ctrl #(
    .POLY_DEG (POLY_DEG)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .bitValid    (bitValid),
    .bitLast     (bitLast),
    .strobe      (strobe),
    .busy        (busy),
    .done        (done),
    .resultValid (resultValid)
  );

  crc_div_dp #(
    .POLY_DEG  (POLY_DEG),
    .POLY_TAPS (POLY_TAPS)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .bitIn  (bitIn),
    .remQ   (remainder)
  );

  assign chkErr = resultValid && (remainder != '0);

  AST_REM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (resultValid && !start) |=> $stable(remainder)); // R5
  AST_ERR_NEEDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    chkErr |-> resultValid); // R7

endmodule

// File: tb/serial_crc_div_bench.sv
module serial_crc_div_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, bitValid = 1'b0, bitIn = 1'b0, bitLast = 1'b0;

  logic [2:0]  rem3;
  logic [15:0] rem16;
  logic [31:0] rem32;
  logic busy3, done3, rv3, err3;
  logic busy16, done16, rv16, err16;
  logic busy32, done32, rv32, err32;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  serial_crc_div #(.POLY_DEG(3), .POLY_TAPS(3'b011)) u_serial_crc_div (
    .clk(clk), .rst_n(rst_n), .start(start), .bitValid(bitValid), .bitIn(bitIn),
    .bitLast(bitLast), .remainder(rem3), .busy(busy3), .done(done3),
    .resultValid(rv3), .chkErr(err3));

  serial_crc_div #(.POLY_DEG(16), .POLY_TAPS(16'h1021)) u_serial_crc_div_w16 (
    .clk(clk), .rst_n(rst_n), .start(start), .bitValid(bitValid), .bitIn(bitIn),
    .bitLast(bitLast), .remainder(rem16), .busy(busy16), .done(done16),
    .resultValid(rv16), .chkErr(err16));

  serial_crc_div #(.POLY_DEG(32), .POLY_TAPS(32'h04C11DB7)) u_serial_crc_div_w32 (
    .clk(clk), .rst_n(rst_n), .start(start), .bitValid(bitValid), .bitIn(bitIn),
    .bitLast(bitLast), .remainder(rem32), .busy(busy32), .done(done32),
    .resultValid(rv32), .chkErr(err32));

  function automatic logic [31:0] modelRem(input logic [31:0] taps, input int deg,
                                           input logic [63:0] bits, input int n);
    logic [31:0] r = '0;
    logic [31:0] mask = (32'd1 << deg) - 32'd1;
    for (int i = 0; i < n + deg; i++) begin
      logic b = (i < n) ? bits[n-1-i] : 1'b0;
      logic t = r[deg-1];
      r = ({r[30:0], b}) & mask;
      if (t) r = r ^ (taps & mask);
    end
    return r;
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic feedBits(input logic [63:0] bits, input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        bitValid = 1'b0; bitIn = 1'($urandom); bitLast = 1'($urandom);
        @(negedge clk);
      end
      bitValid = 1'b1; bitIn = bits[n-1-i]; bitLast = (i == n - 1);
      @(negedge clk);
    end
    bitValid = 1'b0; bitIn = 1'b0; bitLast = 1'b0;
  endtask

  task automatic sendMsg(input logic [63:0] bits, input int n, input bit gaps);
    @(negedge clk);
    start = 1'b1; bitValid = 1'b0; bitLast = 1'b0;
    @(negedge clk);
    start = 1'b0;
    feedBits(bits, n, gaps);
  endtask

  task automatic finishMsg(input logic [63:0] bits, input int n, input bit noise);
    logic [31:0] m3  = modelRem(32'h3, 3, bits, n);
    logic [31:0] m16 = modelRem(32'h1021, 16, bits, n);
    logic [31:0] m32 = modelRem(32'h04C11DB7, 32, bits, n);
    int d3 = -1, d16 = -1, d32 = -1;
    int c3 = 0, c16 = 0, c32 = 0;
    logic [2:0] s3; logic [15:0] s16; logic [31:0] s32;
    for (int k = 1; k <= 40; k++) begin
      if (noise) begin
        bitValid = 1'($urandom); bitIn = 1'($urandom); bitLast = 1'($urandom);
      end
      @(negedge clk);
      if (done3)  begin c3++;  d3 = k;  end
      if (done16) begin c16++; d16 = k; end
      if (done32) begin c32++; d32 = k; end
    end
    bitValid = 1'b0; bitIn = 1'b0; bitLast = 1'b0;
    // R3 / R4: done one cycle, POLY_DEG cycles after the last bit
    chk(c3 == 1 && d3 == 3, "R4", "done3 cycle", 32'(d3), 32'd3);
    chk(c16 == 1 && d16 == 16, "R3", "done16 cycle", 32'(d16), 32'd16);
    chk(c32 == 1 && d32 == 32, "R4", "done32 cycle", 32'(d32), 32'd32);
    chk(rem3 == m3[2:0], "R4", "rem3", 32'(rem3), m3);
    chk(rem16 == m16[15:0], "R8", "rem16", 32'(rem16), m16);
    chk(rem32 == m32, "R8", "rem32", rem32, m32);
    chk(rv3 && rv16 && rv32 && !busy3 && !busy16 && !busy32, "R5", "resultValid/busy",
        {26'd0, rv3, rv16, rv32, busy3, busy16, busy32}, 32'h38);
    chk(err3 == (m3 != 0) && err16 == (m16 != 0) && err32 == (m32 != 0), "R7", "chkErr",
        {29'd0, err3, err16, err32}, {29'd0, m3 != 0, m16 != 0, m32 != 0});
    // R2 / R5: idle inputs change nothing
    s3 = rem3; s16 = rem16; s32 = rem32;
    for (int k = 0; k < 4; k++) begin
      bitValid = 1'($urandom); bitIn = 1'($urandom); bitLast = 1'($urandom);
      @(negedge clk);
    end
    bitValid = 1'b0; bitIn = 1'b0; bitLast = 1'b0;
    chk(rem3 == s3 && rem16 == s16 && rem32 == s32 && rv32, "R2", "idle hold",
        rem32, s32);
  endtask

  initial begin
    logic [63:0] msg, cw;
    logic [31:0] r;
    int n;
    void'($urandom(32'h5EED_C0DE));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(rem3 == 0 && rem16 == 0 && rem32 == 0, "R1", "reset remainder", rem32, 0);
    chk(!busy3 && !done3 && !rv3 && !err3 && !busy32 && !rv16, "R1", "reset flags",
        {28'd0, busy3, done3, rv3, err3}, 0);

    // R6: 1100 with x^3+x+1
    sendMsg(64'b1100, 4, 1'b0);
    finishMsg(64'b1100, 4, 1'b0);
    chk(rem3 == 3'b010, "R6", "1100 remainder", 32'(rem3), 32'b010);

    // R7: valid codeword 1100010, then one flipped bit
    sendMsg(64'b1100010, 7, 1'b0);
    finishMsg(64'b1100010, 7, 1'b1);
    chk(rem3 == 0 && !err3, "R7", "clean codeword", 32'(rem3), 0);
    sendMsg(64'b1101010, 7, 1'b0);
    finishMsg(64'b1101010, 7, 1'b0);
    chk(err3 == 1'b1, "R7", "corrupted codeword", 32'(err3), 1);

    // R8: 16- and 32-bit codewords built by the model
    msg = 64'($urandom) & 64'hFFFF;
    r = modelRem(32'h1021, 16, msg, 16);
    cw = (msg << 16) | 64'(r[15:0]);
    sendMsg(cw, 32, 1'b1);
    finishMsg(cw, 32, 1'b1);
    chk(rem16 == 0 && !err16, "R8", "16-bit codeword", 32'(rem16), 0);
    cw = cw ^ (64'd1 << ($urandom % 32));
    sendMsg(cw, 32, 1'b0);
    finishMsg(cw, 32, 1'b0);
    chk(err16 == 1'b1, "R7", "16-bit flipped", 32'(err16), 1);

    msg = 64'($urandom);
    r = modelRem(32'h04C11DB7, 32, msg, 32);
    cw = (msg << 32) | 64'(r);
    sendMsg(cw, 64, 1'b1);
    finishMsg(cw, 64, 1'b1);
    chk(rem32 == 0 && !err32, "R8", "32-bit codeword", rem32, 0);

    // R1: restart in the middle of a message
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    feedBits(64'h3F, 6, 1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(rem3 == 0 && rem16 == 0 && rem32 == 0, "R1", "restart clears", rem32, 0);
    chk(busy3 && busy32 && !rv3 && !done3, "R1", "restart flags",
        {28'd0, busy3, busy32, rv3, done3}, 32'hC);
    msg = 64'($urandom) & 64'h3FF;
    feedBits(msg, 10, 1'b1);
    finishMsg(msg, 10, 1'b1);

    // R2 / R3: random messages with valid gaps and flush noise
    for (int t = 0; t < 40; t++) begin
      n = 1 + int'($urandom % 48);
      msg = {32'($urandom), 32'($urandom)};
      sendMsg(msg, n, 1'b1);
      finishMsg(msg, n, 1'b1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule